// File: doc/BRIEF.md
# Holdover Frequency History Averager

This block keeps a running record of the frequency words a phase-locked loop reports while it is locked to a good input. From that record it produces the frequency the loop should hold if the input disappears. On every accepted sample strobe the word goes into a circular history. The block then recomputes the exact mean of a window of older samples. The newest samples are skipped, so that a frequency disturbance caused by the input being pulled out never reaches the held value.

Both the window and the skipped region are set by exponents. The window covers 2^L − 1 samples and the skipped region covers 2^D samples. A history-valid flag tells the loop controller whether a held value exists, which decides between holdover and free run. While the lock flag is low the history pauses: strobes are dropped, the fill level is kept and the held output does not move. The history carries on from where it stopped when lock returns.

Top module: `hold_hist_avg`

## Requirements
- R1: After reset, `hold_freq` is 0 and `hist_ok` is 0.
- R2: The averaging window is W = 2^L − 1 samples, where L is `win_exp` clamped to the range 1 to MAX_L (default 5). A value of 0 acts as 1, and values above MAX_L act as MAX_L.
- R3: The skipped recent region is S = 2^D samples, where D is `dly_exp` clamped to at most MAX_D (default 5).
- R4: Age 0 is the newest accepted sample. Once at least S + W samples have been accepted since the history last started, every accepted sample updates `hold_freq` to floor(sum of the samples of age S to S+W−1, divided by W). The new value appears within FREQ_W + MAX_L + 3 clock cycles of the strobe.
- R5: `hist_ok` rises at the clock edge that accepts the (S+W)-th sample after the history started. `hold_freq` keeps its previous value until then.
- R6: A strobe while `in_lock` is 0 is ignored: it adds nothing to the history and does not advance the fill level.
- R7: While `in_lock` is 0, `hold_freq` is held stable and `hist_ok` keeps its value.
- R8: A change in the effective L or D restarts the history. `hist_ok` clears and the fill level returns to zero, while `hold_freq` keeps its last value until the new window is full. A change in the raw fields that leaves the clamped values unchanged has no effect.
- R9: `hist_ok` falls only on reset or on a restart under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_freq | input | FREQ_W | Frequency word taken on the strobe |
| in_lock | input | 1 | 1 while the loop is locked to a valid input |
| win_exp | input | EXP_W | Window exponent L |
| dly_exp | input | EXP_W | Skipped-region exponent D |
| hold_freq | output | FREQ_W | Averaged holdover frequency |
| hist_ok | output | 1 | History holds a full window |

## Verification
The assertions take for granted that strobes are at least FREQ_W + MAX_L + 2 cycles apart, so that a division is never started while the previous one is still running. They also assume the exponents do not change within a few cycles of a strobe. The stimulus spaces strobes 32 cycles apart. It changes the exponents only when the block is idle and waits four cycles before the next strobe. Lock is dropped only after the last division has finished, so the frozen output is a fully computed average.

// File: rtl/hha_pkg.sv
package hha_pkg;

   // window exponent: zero would mean an empty window, so it acts as one
   function automatic int unsigned clamp_win_exp(input int unsigned raw, input int unsigned max_e);
      if (raw == 0)
         return 1;
      else if (raw > max_e)
         return max_e;
      else
         return raw;
   endfunction

   function automatic int unsigned clamp_dly_exp(input int unsigned raw, input int unsigned max_e);
      if (raw > max_e)
         return max_e;
      else
         return raw;
   endfunction

endpackage

// File: rtl/hha_cfg.sv
module hha_cfg
   import hha_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAX_L = 5,
   parameter int MAX_D = 5,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] win_exp,
   input  logic [EXP_W-1:0] dly_exp,
   output logic [CNT_W-1:0] win_len,
   output logic [CNT_W-1:0] dly_len,
   output logic [CNT_W-1:0] span_len,
   output logic             restart
);

   logic [EXP_W-1:0] l_eff, d_eff;
   logic [EXP_W-1:0] l_q, d_q;

   always_comb begin
      l_eff = EXP_W'(clamp_win_exp(32'(win_exp), 32'(MAX_L)));
      d_eff = EXP_W'(clamp_dly_exp(32'(dly_exp), 32'(MAX_D)));
   end

   // the reset loads the present setting so that leaving reset is no restart
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_q     <= l_eff;
         d_q     <= d_eff;
         restart <= 1'b0;
      end else begin
         restart <= (l_eff != l_q) || (d_eff != d_q);
         l_q     <= l_eff;
         d_q     <= d_eff;
      end
   end

   assign win_len  = CNT_W'((32'd1 << l_q) - 32'd1);
   assign dly_len  = CNT_W'(32'd1 << d_q);
   assign span_len = win_len + dly_len;

   // R8
   cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(win_len) || !$stable(dly_len)) |-> restart);

endmodule

// File: rtl/hha_ring.sv
module hha_ring #(
   parameter int FREQ_W   = 16,
   parameter int DEPTH_LG = 6,
   parameter int CNT_W    = 7,
   parameter int SUM_W    = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              smp_stb,
   input  logic              in_lock,
   input  logic [FREQ_W-1:0] smp_freq,
   input  logic [CNT_W-1:0]  dly_len,
   input  logic [CNT_W-1:0]  span_len,
   output logic [SUM_W-1:0]  run_sum,
   output logic              hist_ok,
   output logic              win_go
);

   localparam int DEPTH = 1 << DEPTH_LG;

   logic [FREQ_W-1:0]   mem [DEPTH];
   logic [DEPTH_LG-1:0] wp;
   logic [DEPTH_LG-1:0] ent_ix, lev_ix;
   logic [CNT_W-1:0]    fill;
   logic [CNT_W-1:0]    fill_inc;
   logic [FREQ_W-1:0]   ent_v, lev_v;
   logic [SUM_W-1:0]    sum_nxt;
   logic                take;

   assign take = smp_stb && in_lock && !restart;

   // indices are read before the write, so ages are shifted by one here
   always_comb begin
      ent_ix   = wp - dly_len[DEPTH_LG-1:0];
      lev_ix   = wp - span_len[DEPTH_LG-1:0];
      ent_v    = (fill >= dly_len)  ? mem[ent_ix] : '0;
      lev_v    = (fill >= span_len) ? mem[lev_ix] : '0;
      fill_inc = fill + CNT_W'(1);
      sum_nxt  = run_sum + SUM_W'(ent_v) - SUM_W'(lev_v);
   end

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem[gi] <= '0;
            else if (take && (wp == DEPTH_LG'(gi)))
               mem[gi] <= smp_freq;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp      <= '0;
         fill    <= '0;
         run_sum <= '0;
         hist_ok <= 1'b0;
         win_go  <= 1'b0;
      end else begin
         win_go <= 1'b0;
         if (restart) begin
            fill    <= '0;
            run_sum <= '0;
            hist_ok <= 1'b0;
         end else if (take) begin
            wp      <= wp + DEPTH_LG'(1);
            run_sum <= sum_nxt;
            if (fill < span_len)
               fill <= fill_inc;
            if (fill_inc >= span_len) begin
               hist_ok <= 1'b1;
               win_go  <= 1'b1;
            end
         end
      end
   end

   // R5
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (fill <= span_len));

   // R9
   valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hist_ok) |-> $past(restart));

   // R5
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hist_ok) |-> $past(smp_stb && in_lock));

   // R6
   unlocked_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !in_lock && !restart) |=> ($stable(run_sum) && $stable(wp)));

endmodule

// File: rtl/hha_div.sv
module hha_div #(
   parameter int N_W = 21,
   parameter int D_W = 7,
   parameter bit SEQ = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N_W-1:0] num,
   input  logic [D_W-1:0] den,
   output logic           done,
   output logic [N_W-1:0] quo
);

   localparam int STEP_W = $clog2(N_W + 1);

   logic [N_W-1:0] num_q;
   logic [D_W-1:0] den_q;
   logic           busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q <= '0;
         den_q <= D_W'(1);
      end else if (start) begin
         num_q <= num;
         den_q <= den;
      end
   end

   generate
      if (SEQ) begin : g_seq
         logic [N_W-1:0]    q;
         logic [D_W-1:0]    r;
         logic [D_W:0]      r_sh;
         logic [STEP_W-1:0] steps;
         logic              run, fin;

         assign r_sh = {r, q[N_W-1]};

         // one quotient bit per cycle, restoring
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q     <= '0;
               r     <= '0;
               steps <= '0;
               run   <= 1'b0;
               fin   <= 1'b0;
            end else begin
               fin <= 1'b0;
               if (start) begin
                  q     <= num;
                  r     <= '0;
                  steps <= STEP_W'(N_W);
                  run   <= 1'b1;
               end else if (run) begin
                  if (r_sh >= {1'b0, den_q}) begin
                     r <= D_W'(r_sh - {1'b0, den_q});
                     q <= {q[N_W-2:0], 1'b1};
                  end else begin
                     r <= r_sh[D_W-1:0];
                     q <= {q[N_W-2:0], 1'b0};
                  end
                  steps <= steps - STEP_W'(1);
                  if (steps == STEP_W'(1)) begin
                     run <= 1'b0;
                     fin <= 1'b1;
                  end
               end
            end
         end
         assign done = fin;
         assign quo  = q;
         assign busy = run;
      end else begin : g_flat
         logic [N_W-1:0] q;
         logic           fin;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q   <= '0;
               fin <= 1'b0;
            end else begin
               fin <= start;
               if (start)
                  q <= num / {{(N_W-D_W){1'b0}}, den};
            end
         end
         assign done = fin;
         assign quo  = q;
         assign busy = 1'b0;
      end
   endgenerate

   logic [N_W+D_W-1:0] prod_lo, prod_hi, num_x;
   assign prod_lo = {{D_W{1'b0}}, quo} * {{N_W{1'b0}}, den_q};
   assign prod_hi = prod_lo + {{N_W{1'b0}}, den_q};
   assign num_x   = {{D_W{1'b0}}, num_q};

   // R4
   div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((prod_lo <= num_x) && (num_x < prod_hi)));

   // R4
   div_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/hold_hist_avg.sv
module hold_hist_avg
   import hha_pkg::*;
#(
   parameter int FREQ_W   = 16,
   parameter int DEPTH_LG = 6,
   parameter int EXP_W    = 5,
   parameter int MAX_L    = 5,
   parameter int MAX_D    = 5,
   parameter bit SEQ_DIV  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic [FREQ_W-1:0] smp_freq,
   input  logic              in_lock,
   input  logic [EXP_W-1:0]  win_exp,
   input  logic [EXP_W-1:0]  dly_exp,
   output logic [FREQ_W-1:0] hold_freq,
   output logic              hist_ok
);

   localparam int CNT_W = DEPTH_LG + 1;
   localparam int SUM_W = FREQ_W + MAX_L;

   initial begin
      cfg_win_min_chk: assert (MAX_L >= 1);
      cfg_exp_w_chk:   assert ((MAX_L < (1 << EXP_W)) && (MAX_D < (1 << EXP_W)));
      cfg_depth_chk:   assert (((1 << MAX_L) - 1 + (1 << MAX_D)) <= (1 << DEPTH_LG));
      cfg_width_chk:   assert (SUM_W > CNT_W);
   end

   logic [CNT_W-1:0] win_len, dly_len, span_len;
   logic             restart;
   logic [SUM_W-1:0] run_sum;
   logic             win_go;
   logic             div_done;
   logic [SUM_W-1:0] div_quo;

   hha_cfg #(
      .EXP_W (EXP_W),
      .MAX_L (MAX_L),
      .MAX_D (MAX_D),
      .CNT_W (CNT_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_exp  (win_exp),
      .dly_exp  (dly_exp),
      .win_len  (win_len),
      .dly_len  (dly_len),
      .span_len (span_len),
      .restart  (restart)
   );

   hha_ring #(
      .FREQ_W   (FREQ_W),
      .DEPTH_LG (DEPTH_LG),
      .CNT_W    (CNT_W),
      .SUM_W    (SUM_W)
   ) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .smp_stb  (smp_stb),
      .in_lock  (in_lock),
      .smp_freq (smp_freq),
      .dly_len  (dly_len),
      .span_len (span_len),
      .run_sum  (run_sum),
      .hist_ok  (hist_ok),
      .win_go   (win_go)
   );

   hha_div #(
      .N_W (SUM_W),
      .D_W (CNT_W),
      .SEQ (SEQ_DIV)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (win_go),
      .num   (run_sum),
      .den   (win_len),
      .done  (div_done),
      .quo   (div_quo)
   );

   // the held value only moves while locked
   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_freq <= '0;
      else if (div_done && in_lock)
         hold_freq <= div_quo[FREQ_W-1:0];
   end

   // R7
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_lock && $past(!in_lock)) |-> $stable(hold_freq));

   // R7
   valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_lock && !restart) |=> (hist_ok == $past(hist_ok)));

   // R4
   quo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |-> (div_quo[SUM_W-1:FREQ_W] == '0));

endmodule

// File: tb/tb_hold_hist_avg.sv
module tb_hold_hist_avg;

   localparam int FW = 16;
   localparam int EW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          smp_stb;
   logic [FW-1:0] smp_freq;
   logic          in_lock;
   logic [EW-1:0] win_exp, dly_exp;
   logic [FW-1:0] hold_freq;
   logic          hist_ok;

   always #5 clk = ~clk;

   hold_hist_avg dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_stb   (smp_stb),
      .smp_freq  (smp_freq),
      .in_lock   (in_lock),
      .win_exp   (win_exp),
      .dly_exp   (dly_exp),
      .hold_freq (hold_freq),
      .hist_ok   (hist_ok)
   );

   int          errors = 0;
   int          checks = 0;
   bit          finished = 1'b0;
   int          samp [0:1023];
   int          n;
   longint      exp_avg;
   int unsigned seed = 32'h1234_5678;

   function automatic int effl(input int raw);
      if (raw == 0) return 1;
      if (raw > 5) return 5;
      return raw;
   endfunction

   function automatic int effd(input int raw);
      if (raw > 5) return 5;
      return raw;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_val();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 8) & 32'hFFFF);
   endfunction

   task automatic pulse(input int v);
      @(negedge clk);
      smp_freq = v[FW-1:0];
      smp_stb  = 1'b1;
      @(negedge clk);
      smp_stb  = 1'b0;
      repeat (30) @(negedge clk);
   endtask

   // model of one accepted sample
   task automatic accept(input int v, input int w, input int s);
      longint acc;
      samp[n] = v;
      n++;
      if (n >= w + s) begin
         acc = 0;
         for (int a = s; a < s + w; a++)
            acc += samp[n-1-a];
         exp_avg = acc / w;
      end
   endtask

   int lvals [7] = '{0, 1, 2, 3, 4, 5, 9};
   int dvals [7] = '{0, 1, 2, 3, 4, 5, 17};

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int pl, pd, w, s, v;
      rst_n    = 1'b0;
      smp_stb  = 1'b0;
      smp_freq = '0;
      in_lock  = 1'b1;
      win_exp  = EW'(lvals[0]);
      dly_exp  = EW'(dvals[0]);
      repeat (4) @(negedge clk);
      chk("R1 reset hold_freq", hold_freq, 0);
      chk("R1 reset hist_ok", hist_ok, 0);
      rst_n = 1'b1;
      @(negedge clk);
      n = 0;
      exp_avg = 0;
      pl = effl(lvals[0]);
      pd = effd(dvals[0]);

      foreach (lvals[li]) begin
         foreach (dvals[di]) begin
            @(negedge clk);
            win_exp = EW'(lvals[li]);
            dly_exp = EW'(dvals[di]);
            repeat (4) @(negedge clk);
            // R8: restart only when the clamped setting changes
            if (effl(lvals[li]) != pl || effd(dvals[di]) != pd)
               n = 0;
            pl = effl(lvals[li]);
            pd = effd(dvals[di]);
            w  = (1 << pl) - 1;   // R2 window with clamping
            s  = 1 << pd;         // R3 delay with clamping
            chk("R8 hist_ok after setting change", hist_ok, (n >= w + s) ? 1 : 0);
            chk("R8 hold_freq kept over restart", hold_freq, exp_avg);
            for (int i = 0; i < w + s + 6; i++) begin
               if (i == w + s + 2) begin
                  @(negedge clk);
                  in_lock = 1'b0;
                  repeat (2) @(negedge clk);
                  for (int j = 0; j < 3; j++) begin
                     pulse(next_val());
                     chk("R7 hold_freq frozen while unlocked", hold_freq, exp_avg);
                     chk("R7 hist_ok kept while unlocked", hist_ok, (n >= w + s) ? 1 : 0);
                  end
                  @(negedge clk);
                  in_lock = 1'b1;
                  repeat (2) @(negedge clk);
               end
               v = next_val();
               pulse(v);
               accept(v, w, s);
               // R6: earlier unlocked strobes are absent from the model
               chk("R2 R3 R4 R6 averaged window", hold_freq, exp_avg);
               chk("R5 R9 hist_ok level", hist_ok, (n >= w + s) ? 1 : 0);
            end
         end
      end

      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 mid-run reset hold_freq", hold_freq, 0);
      chk("R1 mid-run reset hist_ok", hist_ok, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pulse(next_val());
      chk("R5 hist_ok low after one sample", hist_ok, 0);
      chk("R5 hold_freq unchanged before full", hold_freq, 0);

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule